// File: doc/BRIEF.md
# CBC Block-Cipher DMA Engine

This block is a small memory-to-memory mover that works in units of 128-bit blocks. Software programs a source and a destination address, loads a 128-bit key and a 128-bit initial vector, and starts a command through one control word. The engine then reads each block from memory and either sends it through an external block-cipher core in cipher-block-chaining (CBC) mode or writes it back unchanged. The cipher rounds are not part of this block. It reaches them through a request/acknowledge port and supplies the key and the direction on that port.

The chaining value can carry over from one command into the next. A long message can therefore be processed as several commands without reloading the IV. The address registers advance in place as blocks complete, so software can read how far a command got. An optional level interrupt marks the end of a command. An interrupt stays raised until the control word is written again.

Top module: `cbc_dma_ctrl`

## Requirements
- R1: After a synchronous reset, every readable register reads 0, `irq` is 0, and no memory or cipher request is active.
- R2: Register index 0 is control, 1 is source, 2 is destination, 3 is the key loader and 4 is the IV loader. A read returns data on `reg_rdata` one cycle after `reg_rd`. Indices 3 and 4 read as 0. The control word has these bits: 31 busy (write: start), 30 interrupt enable, 29 error, 28 cipher enable, 27 decrypt, 12 chain-continue, 11:0 block count. All other bits read 0.
- R3: A command processes (block count + 1) blocks. Source and destination each advance by 16 per completed block, and the advanced values can be read back when the command ends.
- R4: With cipher enable clear, each block is written to the destination unchanged and the cipher port is never requested.
- R5: With cipher enable set and decrypt clear, the cipher input is the plaintext XOR the chaining value. The cipher output is written to the destination and becomes the new chaining value.
- R6: With decrypt set, the cipher input is the ciphertext read from memory. The cipher output XOR the chaining value is written to the destination, and the ciphertext read becomes the new chaining value.
- R7: With chain-continue set, the first block uses the chaining value left by the previous command. With it clear, the first block uses the most recently loaded IV.
- R8: The key and the IV are each loaded by four 32-bit writes, most significant word first, and are presented as a 128-bit value. The write position wraps after the fourth word, so a fifth write replaces the most significant word.
- R9: A control write with bit 31 = 0 stops any command at once, clears busy and error, drops all requests, and sets both loader write positions back to the first word. The key and IV contents are kept.
- R10: If the source or destination address has any of bits 3:0 set when a start is written, the error bit is set, the engine stays idle and no memory access is made. Every memory address the engine issues is 16-byte aligned.
- R11: When interrupt enable is set, `irq` rises when the last block of a command is written. It stays high until the next accepted control write. With interrupt enable clear, `irq` stays 0.
- R12: A memory or cipher request keeps its address, direction and data steady until it is acknowledged. Memory and cipher requests are never active together.
- R13: While busy, writes to the source, destination, key and IV registers are ignored, and a control write with bit 31 = 1 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, valid one cycle after `reg_rd` |
| mem_req | output | 1 | Memory request, held until `mem_ack` |
| mem_we | output | 1 | 1 for a memory write, 0 for a read |
| mem_addr | output | 32 | Byte address of the block |
| mem_wdata | output | 128 | Block to write |
| mem_ack | input | 1 | Memory acknowledge; read data valid with it |
| mem_rdata | input | 128 | Block read from memory |
| cph_req | output | 1 | Cipher request, held until `cph_ack` |
| cph_dec | output | 1 | Cipher direction, 1 = decrypt |
| cph_key | output | 128 | Loaded key |
| cph_din | output | 128 | Cipher input block |
| cph_ack | input | 1 | Cipher acknowledge; result valid with it |
| cph_dout | input | 128 | Cipher result block |
| irq | output | 1 | Command-complete interrupt (level) |

## Verification
The bench's stand-in cipher is a keyed byte rotation, and the bench has the exact inverse of it. So encrypted output checks the XOR placement, the key word order and the chaining update, while decrypting that output must give back the original plaintext. Copy commands use distinct per-block patterns, which exposes dropped, repeated or misaddressed blocks. Single- and multi-block commands, with chain-continue both on and off, show whether the chaining value is taken from the previous command or from the IV. A five-word key load and an abort in the middle of a command show whether the loader position wraps and resets as required. Misaligned starts and writes made while busy show that no memory traffic and no register change result.

// File: rtl/cbc_dma_pkg.sv
package cbc_dma_pkg;
  localparam int REG_W = 32;
  localparam int CNT_W = 12;

  // control word bit positions
  localparam int B_EXEC  = 31;
  localparam int B_IRQ   = 30;
  localparam int B_ERR   = 29;
  localparam int B_ENA   = 28;
  localparam int B_DEC   = 27;
  localparam int B_CHAIN = 12;

  localparam logic [2:0] IDX_CTRL = 3'd0;
  localparam logic [2:0] IDX_SRC  = 3'd1;
  localparam logic [2:0] IDX_DST  = 3'd2;
  localparam logic [2:0] IDX_KEY  = 3'd3;
  localparam logic [2:0] IDX_IV   = 3'd4;

  typedef enum logic [1:0] {ST_IDLE, ST_READ, ST_CIPH, ST_WRITE} eng_state_t;

  typedef struct packed {
    logic             irq_en;
    logic             ena;
    logic             dec;
    logic             chain;
    logic [CNT_W-1:0] count;
  } cmd_cfg_t;
endpackage

// File: rtl/cbc_word_loader.sv
module cbc_word_loader #(
  parameter int WORD_W = 32,
  parameter int WORDS  = 4
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      clr,
  input  logic                      wr,
  input  logic [WORD_W-1:0]         wdata,
  output logic [WORD_W*WORDS-1:0]   value
);
  localparam int PTR_W = (WORDS > 1) ? $clog2(WORDS) : 1;

  logic [PTR_W-1:0]  ptr_q;
  logic [WORD_W-1:0] word_q [WORDS];

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q <= '0;
      for (int i = 0; i < WORDS; i++) word_q[i] <= '0;
    end else begin
      if (clr)
        ptr_q <= '0;
      else if (wr)
        ptr_q <= (ptr_q == PTR_W'(WORDS-1)) ? '0 : ptr_q + 1'b1;
      for (int i = 0; i < WORDS; i++)
        if (wr && !clr && ptr_q == PTR_W'(i)) word_q[i] <= wdata;
    end
  end

  // word 0 is the most significant
  for (genvar g = 0; g < WORDS; g++) begin : g_pack
    assign value[(WORDS-1-g)*WORD_W +: WORD_W] = word_q[g];
  end
endmodule

// File: rtl/cbc_chain_unit.sv
module cbc_chain_unit #(
  parameter int BLK_W = 128
) (
  input  logic             dec,
  input  logic [BLK_W-1:0] chain,
  input  logic [BLK_W-1:0] blk_in,
  input  logic [BLK_W-1:0] cph_out,
  output logic [BLK_W-1:0] cph_in,
  output logic [BLK_W-1:0] blk_out
);
  // encrypt: whiten before the cipher; decrypt: unwhiten after it
  assign cph_in  = dec ? blk_in : (blk_in ^ chain);
  assign blk_out = dec ? (cph_out ^ chain) : cph_out;
endmodule

// File: rtl/cbc_dma_ctrl.sv
module cbc_dma_ctrl
  import cbc_dma_pkg::*;
#(
  parameter int BLK_W = 128
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               reg_wr,
  input  logic               reg_rd,
  input  logic [2:0]         reg_addr,
  input  logic [REG_W-1:0]   reg_wdata,
  output logic [REG_W-1:0]   reg_rdata,
  output logic               mem_req,
  output logic               mem_we,
  output logic [REG_W-1:0]   mem_addr,
  output logic [BLK_W-1:0]   mem_wdata,
  input  logic               mem_ack,
  input  logic [BLK_W-1:0]   mem_rdata,
  output logic               cph_req,
  output logic               cph_dec,
  output logic [BLK_W-1:0]   cph_key,
  output logic [BLK_W-1:0]   cph_din,
  input  logic               cph_ack,
  input  logic [BLK_W-1:0]   cph_dout,
  output logic               irq
);
  localparam int WORDS      = BLK_W / REG_W;
  localparam int STEP       = BLK_W / 8;
  localparam int ALIGN_BITS = $clog2(STEP);

  eng_state_t       st_q;
  cmd_cfg_t         cfg_q;
  logic             busy_q, err_q, irq_q;
  logic [REG_W-1:0] src_q, dst_q;
  logic [CNT_W-1:0] left_q;
  logic [BLK_W-1:0] chain_q, blk_q;
  logic [BLK_W-1:0] key_val, iv_val, c_in, w_out;
  logic [REG_W-1:0] ctrl_word;
  cmd_cfg_t         cfg_new;

  logic ctrl_wr, abort, start, misalign, key_wr, iv_wr;

  assign ctrl_wr  = reg_wr && (reg_addr == IDX_CTRL);
  assign abort    = ctrl_wr && !reg_wdata[B_EXEC];
  assign start    = ctrl_wr && reg_wdata[B_EXEC] && !busy_q;
  assign misalign = |(src_q[ALIGN_BITS-1:0] | dst_q[ALIGN_BITS-1:0]);
  assign key_wr   = reg_wr && (reg_addr == IDX_KEY) && !busy_q;
  assign iv_wr    = reg_wr && (reg_addr == IDX_IV)  && !busy_q;

  assign cfg_new.irq_en = reg_wdata[B_IRQ];
  assign cfg_new.ena    = reg_wdata[B_ENA];
  assign cfg_new.dec    = reg_wdata[B_DEC];
  assign cfg_new.chain  = reg_wdata[B_CHAIN];
  assign cfg_new.count  = reg_wdata[CNT_W-1:0];

  cbc_word_loader #(.WORD_W(REG_W), .WORDS(WORDS)) u_key (
    .clk(clk), .rst(rst), .clr(abort), .wr(key_wr), .wdata(reg_wdata), .value(key_val));

  cbc_word_loader #(.WORD_W(REG_W), .WORDS(WORDS)) u_iv (
    .clk(clk), .rst(rst), .clr(abort), .wr(iv_wr), .wdata(reg_wdata), .value(iv_val));

  cbc_chain_unit #(.BLK_W(BLK_W)) u_chain (
    .dec(cfg_q.dec), .chain(chain_q), .blk_in(mem_rdata), .cph_out(cph_dout),
    .cph_in(c_in), .blk_out(w_out));

  always_comb begin
    ctrl_word            = '0;
    ctrl_word[B_EXEC]    = busy_q;
    ctrl_word[B_IRQ]     = cfg_q.irq_en;
    ctrl_word[B_ERR]     = err_q;
    ctrl_word[B_ENA]     = cfg_q.ena;
    ctrl_word[B_DEC]     = cfg_q.dec;
    ctrl_word[B_CHAIN]   = cfg_q.chain;
    ctrl_word[CNT_W-1:0] = cfg_q.count;
  end

  assign cph_key = key_val;
  assign cph_dec = cfg_q.dec;
  assign irq     = irq_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= ST_IDLE;
      cfg_q     <= '0;
      busy_q    <= 1'b0;
      err_q     <= 1'b0;
      irq_q     <= 1'b0;
      src_q     <= '0;
      dst_q     <= '0;
      left_q    <= '0;
      chain_q   <= '0;
      blk_q     <= '0;
      reg_rdata <= '0;
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      cph_req   <= 1'b0;
      cph_din   <= '0;
    end else begin
      if (reg_rd) begin
        case (reg_addr)
          IDX_CTRL: reg_rdata <= ctrl_word;
          IDX_SRC:  reg_rdata <= src_q;
          IDX_DST:  reg_rdata <= dst_q;
          default:  reg_rdata <= '0;
        endcase
      end
      if (reg_wr && reg_addr == IDX_SRC && !busy_q) src_q <= reg_wdata;
      if (reg_wr && reg_addr == IDX_DST && !busy_q) dst_q <= reg_wdata;

      if (abort) begin
        cfg_q   <= cfg_new;
        err_q   <= 1'b0;
        irq_q   <= 1'b0;
        busy_q  <= 1'b0;
        st_q    <= ST_IDLE;
        mem_req <= 1'b0;
        mem_we  <= 1'b0;
        cph_req <= 1'b0;
      end else if (start) begin
        cfg_q <= cfg_new;
        irq_q <= 1'b0;
        if (misalign) begin
          err_q <= 1'b1;
        end else begin
          err_q    <= 1'b0;
          busy_q   <= 1'b1;
          st_q     <= ST_READ;
          mem_req  <= 1'b1;
          mem_we   <= 1'b0;
          mem_addr <= src_q;
          left_q   <= cfg_new.count;
          if (!cfg_new.chain) chain_q <= iv_val;
        end
      end else begin
        case (st_q)
          ST_READ: if (mem_ack) begin
            blk_q <= mem_rdata;
            if (cfg_q.ena) begin
              mem_req <= 1'b0;
              cph_req <= 1'b1;
              cph_din <= c_in;
              st_q    <= ST_CIPH;
            end else begin
              mem_we    <= 1'b1;
              mem_addr  <= dst_q;
              mem_wdata <= mem_rdata;
              st_q      <= ST_WRITE;
            end
          end
          ST_CIPH: if (cph_ack) begin
            cph_req   <= 1'b0;
            mem_req   <= 1'b1;
            mem_we    <= 1'b1;
            mem_addr  <= dst_q;
            mem_wdata <= w_out;
            chain_q   <= cfg_q.dec ? blk_q : cph_dout;
            st_q      <= ST_WRITE;
          end
          ST_WRITE: if (mem_ack) begin
            src_q  <= src_q + REG_W'(STEP);
            dst_q  <= dst_q + REG_W'(STEP);
            mem_we <= 1'b0;
            if (left_q == '0) begin
              mem_req <= 1'b0;
              busy_q  <= 1'b0;
              irq_q   <= cfg_q.irq_en;
              st_q    <= ST_IDLE;
            end else begin
              left_q   <= left_q - 1'b1;
              mem_addr <= src_q + REG_W'(STEP);
              st_q     <= ST_READ;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/cbc_dma_ctrl_chk.sv
module cbc_dma_ctrl_chk #(
  parameter int ALIGN_BITS = 4,
  parameter int BLK_W      = 128
) (
  input logic             clk,
  input logic             rst,
  input logic             busy,
  input logic             irq,
  input logic             abort,
  input logic             mem_req,
  input logic             mem_we,
  input logic             mem_ack,
  input logic [31:0]      mem_addr,
  input logic             cph_req,
  input logic             cph_ack,
  input logic [BLK_W-1:0] cph_din
);
  // R12: memory request held steady until acknowledged
  a_r12_mem_hold: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack && !abort) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  // R12: cipher request held steady until acknowledged
  a_r12_cph_hold: assert property (@(posedge clk) disable iff (rst)
    (cph_req && !cph_ack && !abort) |=> (cph_req && $stable(cph_din)));

  // R12: never both ports at once
  a_r12_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(mem_req && cph_req));

  // R10: every issued address is block aligned
  a_r10_aligned: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> (mem_addr[ALIGN_BITS-1:0] == '0));

  // R11: the interrupt only shows while idle
  a_r11_irq_idle: assert property (@(posedge clk) disable iff (rst)
    irq |-> !busy);

  // R9: an abort leaves no request behind
  a_r9_abort_quiet: assert property (@(posedge clk) disable iff (rst)
    abort |=> (!mem_req && !cph_req && !busy));
endmodule

bind cbc_dma_ctrl cbc_dma_ctrl_chk #(.ALIGN_BITS(ALIGN_BITS), .BLK_W(BLK_W)) u_chk (
  .clk(clk), .rst(rst), .busy(busy_q), .irq(irq), .abort(abort),
  .mem_req(mem_req), .mem_we(mem_we), .mem_ack(mem_ack), .mem_addr(mem_addr),
  .cph_req(cph_req), .cph_ack(cph_ack), .cph_din(cph_din));

// File: tb/cbc_dma_ctrl_bench.sv
module cbc_dma_ctrl_bench;
  localparam int CLK_PERIOD = 10;

  localparam logic [31:0] C_EXEC = 32'h8000_0000;
  localparam logic [31:0] C_IRQ  = 32'h4000_0000;
  localparam logic [31:0] C_ENA  = 32'h1000_0000;
  localparam logic [31:0] C_DEC  = 32'h0800_0000;
  localparam logic [31:0] C_CHN  = 32'h0000_1000;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0]   reg_addr = '0;
  logic [31:0]  reg_wdata = '0;
  logic [31:0]  reg_rdata;
  logic         mem_req, mem_we, cph_req, cph_dec, irq;
  logic [31:0]  mem_addr;
  logic [127:0] mem_wdata, cph_key, cph_din;
  logic         mem_ack = 1'b0, cph_ack = 1'b0;
  logic [127:0] mem_rdata = '0, cph_dout = '0;

  logic [127:0] mem [64];
  int n_rd = 0, n_wr = 0, n_cph = 0;
  int checks = 0, fails = 0;
  bit done = 0;

  localparam logic [127:0] KEY_A = 128'h0f1e2d3c_4b5a6978_8796a5b4_c3d2e1f0;
  localparam logic [127:0] KEY_B = 128'h11112222_33334444_55556666_77778888;
  localparam logic [127:0] IV_A  = 128'hdeadbeef_01234567_89abcdef_cafef00d;

  cbc_dma_ctrl u_cbc_dma_ctrl (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .cph_req(cph_req), .cph_dec(cph_dec), .cph_key(cph_key), .cph_din(cph_din),
    .cph_ack(cph_ack), .cph_dout(cph_dout), .irq(irq));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [127:0] enc_f(input logic [127:0] x, input logic [127:0] k);
    return {x[119:0], x[127:120]} ^ k;
  endfunction
  function automatic logic [127:0] dec_g(input logic [127:0] y, input logic [127:0] k);
    logic [127:0] t;
    t = y ^ k;
    return {t[7:0], t[127:8]};
  endfunction
  function automatic logic [127:0] pat(input int i);
    return {4{32'hA500_0000 + 32'(i * 32'h0101)}} ^ {96'h0, 32'(i)};
  endfunction

  // memory model: one-cycle acknowledge
  initial begin
    forever begin
      @(negedge clk);
      if (mem_req && !mem_ack) begin
        if (mem_we) begin
          mem[mem_addr[9:4]] = mem_wdata;
          n_wr++;
        end else begin
          mem_rdata = mem[mem_addr[9:4]];
          n_rd++;
        end
        mem_ack = 1'b1;
      end else mem_ack = 1'b0;
    end
  end

  // cipher model
  initial begin
    forever begin
      @(negedge clk);
      if (cph_req && !cph_ack) begin
        cph_dout = cph_dec ? dec_g(cph_din, cph_key) : enc_f(cph_din, cph_key);
        n_cph++;
        cph_ack = 1'b1;
      end else cph_ack = 1'b0;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic reg_write(input logic [2:0] idx, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = idx; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [2:0] idx, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = idx;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic load128(input logic [2:0] idx, input logic [127:0] v);
    reg_write(idx, v[127:96]);
    reg_write(idx, v[95:64]);
    reg_write(idx, v[63:32]);
    reg_write(idx, v[31:0]);
  endtask

  task automatic wait_idle(input string tag);
    logic [31:0] c;
    for (int i = 0; i < 2000; i++) begin
      reg_read(3'd0, c);
      if (!c[31]) return;
    end
    chk(1'b0, tag, 128'(c), 128'h0);
  endtask

  task automatic run(input logic [31:0] src, input logic [31:0] dst, input logic [31:0] ctrl, input string tag);
    reg_write(3'd1, src);
    reg_write(3'd2, dst);
    reg_write(3'd0, ctrl | C_EXEC);
    wait_idle(tag);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    reg_read(3'd0, d); chk(d == 0, "R1 ctrl after reset", 128'(d), 0);
    reg_read(3'd1, d); chk(d == 0, "R1 src after reset", 128'(d), 0);
    chk(!irq && !mem_req && !cph_req, "R1 outputs idle", 128'({irq, mem_req, cph_req}), 0);
  endtask

  task automatic t_bypass();
    logic [31:0] d;
    int r0 = n_rd, w0 = n_wr, c0 = n_cph;
    run(32'h000, 32'h100, 32'd2, "R3 bypass done");
    for (int i = 0; i < 3; i++)
      chk(mem[16+i] == pat(i), "R4 copied block", mem[16+i], pat(i));
    chk(n_cph == c0, "R4 no cipher use", 128'(n_cph - c0), 0);
    chk(n_rd - r0 == 3 && n_wr - w0 == 3, "R3 block count", 128'(n_rd - r0), 3);
    reg_read(3'd1, d); chk(d == 32'h30, "R3 src advanced", 128'(d), 128'h30);
    reg_read(3'd2, d); chk(d == 32'h130, "R3 dst advanced", 128'(d), 128'h130);
    chk(!irq, "R11 no irq when disabled", 128'(irq), 0);
    reg_read(3'd3, d); chk(d == 0, "R2 key reads zero", 128'(d), 0);
  endtask

  task automatic t_encrypt(output logic [127:0] last_ct);
    logic [31:0] d;
    logic [127:0] c0, c1;
    load128(3'd3, KEY_A);
    load128(3'd4, IV_A);
    run(32'h000, 32'h200, C_ENA | 32'd1, "R5 encrypt done");
    c0 = enc_f(pat(0) ^ IV_A, KEY_A);
    c1 = enc_f(pat(1) ^ c0, KEY_A);
    chk(mem[32] == c0, "R5 R8 first ciphertext", mem[32], c0);
    chk(mem[33] == c1, "R5 chained ciphertext", mem[33], c1);
    reg_read(3'd0, d); chk(d == 32'h1000_0001, "R2 ctrl readback", 128'(d), 128'h1000_0001);
    last_ct = c1;
  endtask

  task automatic t_chain(input logic [127:0] prev);
    logic [31:0] d;
    logic [127:0] e;
    run(32'h020, 32'h300, C_ENA | C_CHN, "R7 continue done");
    e = enc_f(pat(2) ^ prev, KEY_A);
    chk(mem[48] == e, "R7 continued chain", mem[48], e);
    reg_read(3'd0, d); chk(d == 32'h1000_1000, "R2 chain bit readback", 128'(d), 128'h1000_1000);
    run(32'h020, 32'h310, C_ENA, "R7 fresh done");
    e = enc_f(pat(2) ^ IV_A, KEY_A);
    chk(mem[49] == e, "R7 fresh IV", mem[49], e);
  endtask

  task automatic t_decrypt();
    run(32'h200, 32'h380, C_ENA | C_DEC | 32'd1, "R6 decrypt done");
    chk(mem[56] == pat(0), "R6 first plaintext", mem[56], pat(0));
    chk(mem[57] == pat(1), "R6 second plaintext", mem[57], pat(1));
  endtask

  task automatic t_wrap();
    logic [127:0] k, e;
    k = {32'h9999_0000, KEY_B[95:0]};
    load128(3'd3, KEY_B);
    reg_write(3'd3, 32'h9999_0000);
    run(32'h000, 32'h280, C_ENA, "R8 wrap done");
    e = enc_f(pat(0) ^ IV_A, k);
    chk(mem[40] == e, "R8 fifth word replaces top", mem[40], e);
    reg_write(3'd0, 32'h0);
  endtask

  task automatic t_irq();
    reg_write(3'd1, 32'h000);
    reg_write(3'd2, 32'h100);
    reg_write(3'd0, C_EXEC | C_IRQ);
    wait_idle("R11 irq cmd done");
    chk(irq, "R11 irq raised", 128'(irq), 1);
    repeat (5) @(negedge clk);
    chk(irq, "R11 irq held", 128'(irq), 1);
    reg_write(3'd0, 32'h0);
    chk(!irq, "R11 irq cleared by ctrl write", 128'(irq), 0);
  endtask

  task automatic t_misalign();
    logic [31:0] d;
    int r0;
    reg_write(3'd1, 32'h008);
    reg_write(3'd2, 32'h100);
    r0 = n_rd + n_wr;
    reg_write(3'd0, C_EXEC);
    repeat (10) @(negedge clk);
    reg_read(3'd0, d);
    chk(d[29] && !d[31], "R10 error set, idle", 128'(d), 128'h2000_0000);
    chk(n_rd + n_wr == r0, "R10 no memory access", 128'(n_rd + n_wr - r0), 0);
    reg_write(3'd0, 32'h0);
    reg_read(3'd0, d);
    chk(!d[29], "R9 error cleared by reset write", 128'(d), 0);
  endtask

  task automatic t_busy_ignore();
    logic [31:0] d;
    reg_write(3'd1, 32'h000);
    reg_write(3'd2, 32'h100);
    reg_write(3'd0, C_EXEC | 32'd7);
    reg_write(3'd1, 32'h3F0);
    reg_write(3'd0, C_EXEC);
    wait_idle("R13 long copy done");
    reg_read(3'd1, d); chk(d == 32'h80, "R13 src write ignored while busy", 128'(d), 128'h80);
    reg_read(3'd2, d); chk(d == 32'h180, "R13 restart ignored while busy", 128'(d), 128'h180);
    chk(mem[23] == pat(7), "R13 all eight blocks copied", mem[23], pat(7));
  endtask

  task automatic t_abort();
    logic [31:0] d;
    logic [127:0] e;
    int s0;
    reg_write(3'd3, 32'h1234_5678);
    reg_write(3'd3, 32'h9abc_def0);
    reg_write(3'd1, 32'h000);
    reg_write(3'd2, 32'h100);
    reg_write(3'd0, C_EXEC | 32'd15);
    repeat (6) @(negedge clk);
    reg_write(3'd0, 32'h0);
    reg_read(3'd0, d);
    chk(!d[31], "R9 busy cleared by abort", 128'(d), 0);
    s0 = n_rd + n_wr + n_cph;
    repeat (20) @(negedge clk);
    chk(n_rd + n_wr + n_cph == s0, "R9 no traffic after abort", 128'(n_rd + n_wr + n_cph - s0), 0);
    load128(3'd3, KEY_B);
    run(32'h030, 32'h3C0, C_ENA, "R9 post-abort done");
    e = enc_f(pat(3) ^ IV_A, KEY_B);
    chk(mem[60] == e, "R9 key position reset", mem[60], e);
  endtask

  initial begin
    repeat (CLK_PERIOD * 20000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL R12 watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [127:0] ct;
    for (int i = 0; i < 64; i++) mem[i] = pat(i);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_bypass();
    t_encrypt(ct);
    t_chain(ct);
    t_decrypt();
    t_wrap();
    t_irq();
    t_misalign();
    t_busy_ignore();
    t_abort();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule